// File: doc/BRIEF.md
# Control Register Mode Tracker

This block is the control-register file of a processor core. It holds the paging and protection control words, the extended-feature register, the flags word, the code-segment attribute word, a derived status word (execution mode, submode and current privilege level) and a time-stamp offset. It has one indexed write port and one combinational read port. Each write also applies its architectural side effects. These include long-mode activation, submode derivation, a forced bit in control word 0, and one-cycle invalidate pulses to an instruction TLB and a data TLB.

The time stamp is virtualised. A free-running cycle counter is added to a stored offset on every read, and a write stores the written value minus the current count. An access to an index that is not architecturally legal is not trapped. The block raises a combinational error flag instead and leaves storage alone.

Index map (5-bit): 0 = CR0, 2 = CR2, 3 = CR3, 4 = CR4, 8 = CR8, 16 = EFER, 17 = flags, 18 = code-segment attribute, 19 = status word, 20 = time stamp. All other indices are illegal.

Top module: `ctl_reg_tracker`

## Requirements
- R1: Active-low `rst_n` (asynchronous) and a high `clr` (synchronous) zero every stored register and the time-stamp offset. `clr` takes priority over a write in the same cycle, and that write produces no pulse.
- R2: Indices 1, 5–7, 9–15 and 21–31 are illegal. `rd_err` is high while `rd_idx` is illegal, and `rd_data` is then 0. `wr_err` is high while `wr_en` is high with an illegal `wr_idx`. An illegal write changes no register.
- R3: A CR0 write that toggles bit 31 (PG) while EFER bit 8 (LME) is 1 sets EFER bit 10 (LMA) and status bit 0 (1 = long mode) to the new PG. With LME at 0, neither changes.
- R4: After every CR0 write, status bits [3:1] hold the submode: 0 real, 1 protected, 2 virtual-8086, 3 compatibility, 4 64-bit. In long mode, attribute bit 9 (long) selects 64-bit, otherwise compatibility. Outside long mode, new CR0 bit 0 (PE) = 0 gives real. PE = 1 gives virtual-8086 when flags bit 17 (VM) is 1, and protected otherwise.
- R5: CR0 bit 4 (ET) is stored as 1 on every CR0 write, whatever value is written.
- R6: A CR0 write that toggles PG raises `itlb_inv_all` and `dtlb_inv_all` for exactly the cycle after the write edge.
- R7: Every CR3 write raises `itlb_inv_ng` and `dtlb_inv_ng` for exactly the cycle after the write edge.
- R8: A CR4 write raises both invalidate-all outputs the next cycle only if it toggles bit 4 (PSE), bit 5 (PAE) or bit 7 (PGE).
- R9: An attribute write copies its bits [6:5] (DPL) into status bits [5:4] (CPL). In long mode, toggling attribute bit 9 sets the submode to 64-bit (new bit 1) or compatibility (new bit 0). Outside long mode, the submode is left alone.
- R10: A time-stamp read returns the stored offset plus a cycle counter that advances by one every clock. A read one cycle after writing V returns V+1 and advances by one per cycle.
- R11: Writes to CR2, CR3, CR4, CR8, EFER, flags, attribute and status store the written value verbatim. Reads are combinational from the current state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all registers |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 5 | Write index |
| wr_data | input | DATA_W | Write value |
| rd_idx | input | 5 | Read index |
| rd_data | output | DATA_W | Read value (combinational) |
| rd_err | output | 1 | Read index illegal |
| wr_err | output | 1 | Write strobe with illegal index |
| itlb_inv_all | output | 1 | Instruction TLB invalidate-all pulse |
| dtlb_inv_all | output | 1 | Data TLB invalidate-all pulse |
| itlb_inv_ng | output | 1 | Instruction TLB invalidate-non-global pulse |
| dtlb_inv_ng | output | 1 | Data TLB invalidate-non-global pulse |

## Verification
Several properties are checked on every cycle:
- the forced ET bit;
- long-mode activation from a PG toggle;
- the copy of DPL into the privilege level;
- the storage freeze on illegal writes;
- zeroing by clear;
- the origin of every non-global flush pulse;
- the value-plus-one law of the time stamp.

Only the bench's scenarios can show the full submode derivation across real, protected, virtual-8086, compatibility and 64-bit. The same holds for the selective CR4 flush mask and the absence of mode change when LME is off. The bench compares every output against a behavioural model on every clock.

// File: rtl/ctrk_pkg.sv
package ctrk_pkg;
   localparam int IDX_W = 5;

   localparam logic [IDX_W-1:0] IX_CR0    = 5'd0;
   localparam logic [IDX_W-1:0] IX_CR2    = 5'd2;
   localparam logic [IDX_W-1:0] IX_CR3    = 5'd3;
   localparam logic [IDX_W-1:0] IX_CR4    = 5'd4;
   localparam logic [IDX_W-1:0] IX_CR8    = 5'd8;
   localparam logic [IDX_W-1:0] IX_EFER   = 5'd16;
   localparam logic [IDX_W-1:0] IX_FLAGS  = 5'd17;
   localparam logic [IDX_W-1:0] IX_CSATTR = 5'd18;
   localparam logic [IDX_W-1:0] IX_STATUS = 5'd19;
   localparam logic [IDX_W-1:0] IX_TSC    = 5'd20;

   // architectural bit positions
   localparam int B_PE   = 0;
   localparam int B_ET   = 4;
   localparam int B_PG   = 31;
   localparam int B_PSE  = 4;
   localparam int B_PAE  = 5;
   localparam int B_PGE  = 7;
   localparam int B_LME  = 8;
   localparam int B_LMA  = 10;
   localparam int B_VM   = 17;
   localparam int B_CSL  = 9;
   localparam int B_DPL  = 5;   // two bits
   // status word layout
   localparam int S_MODE = 0;
   localparam int S_SUB  = 1;   // three bits
   localparam int S_CPL  = 4;   // two bits

   typedef enum logic [2:0] {
      SUB_REAL   = 3'd0,
      SUB_PROT   = 3'd1,
      SUB_V86    = 3'd2,
      SUB_COMPAT = 3'd3,
      SUB_64     = 3'd4
   } submode_e;

   function automatic logic idx_legal(input logic [IDX_W-1:0] i);
      return !(i == 5'd1 || (i >= 5'd5 && i <= 5'd7) ||
               (i >= 5'd9 && i <= 5'd15) || i > IX_TSC);
   endfunction
endpackage

// File: rtl/ctrk_mode.sv
module ctrk_mode
   import ctrk_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W-1:0] cr0_q,
   input  logic [DATA_W-1:0] cr0_new,
   input  logic [DATA_W-1:0] efer_q,
   input  logic [DATA_W-1:0] flags_q,
   input  logic [DATA_W-1:0] csattr_q,
   input  logic [DATA_W-1:0] status_q,
   output logic [DATA_W-1:0] efer_n,
   output logic [DATA_W-1:0] status_n,
   output logic              pg_flip
);
   logic     long_n;
   submode_e sub_n;

   always_comb begin
      pg_flip = cr0_q[B_PG] ^ cr0_new[B_PG];
      efer_n  = efer_q;
      long_n  = status_q[S_MODE];
      if (pg_flip && efer_q[B_LME]) begin
         efer_n[B_LMA] = cr0_new[B_PG];
         long_n        = cr0_new[B_PG];
      end
      if (long_n)
         sub_n = csattr_q[B_CSL] ? SUB_64 : SUB_COMPAT;
      else if (cr0_new[B_PE])
         sub_n = flags_q[B_VM] ? SUB_V86 : SUB_PROT;
      else
         sub_n = SUB_REAL;
      status_n               = status_q;
      status_n[S_MODE]       = long_n;
      status_n[S_SUB+:3]     = sub_n;
   end
endmodule

// File: rtl/ctrk_flush.sv
module ctrk_flush #(
   parameter int NUM_TLB = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fire_all,
   input  logic               fire_ng,
   output logic [NUM_TLB-1:0] inv_all,
   output logic [NUM_TLB-1:0] inv_ng
);
   if (NUM_TLB < 1) begin : g_bad_tlb
      $error("NUM_TLB must be at least 1");
   end

   for (genvar t = 0; t < NUM_TLB; t++) begin : g_tlb
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            inv_all[t] <= 1'b0;
            inv_ng[t]  <= 1'b0;
         end else begin
            inv_all[t] <= fire_all;
            inv_ng[t]  <= fire_ng;
         end
      end
   end
endmodule

// File: rtl/ctrk_tsc.sv
module ctrk_tsc #(
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr_tsc,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] tsc_o
);
   logic [DATA_W-1:0] cyc_q;
   logic [DATA_W-1:0] off_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cyc_q <= '0;
      else        cyc_q <= cyc_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      off_q <= '0;
      else if (clr)    off_q <= '0;
      else if (wr_tsc) off_q <= wr_data - cyc_q;
   end

   assign tsc_o = off_q + cyc_q;

   a_r10_tsc_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_tsc && !clr) |=> tsc_o == $past(wr_data) + 1'b1);
   a_r10_tsc_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(wr_tsc) && !$past(clr) && !wr_tsc && !clr) |=> tsc_o == $past(tsc_o) + 1'b1);
endmodule

// File: rtl/ctl_reg_tracker.sv
module ctl_reg_tracker
   import ctrk_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr_en,
   input  logic [4:0]        wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [4:0]        rd_idx,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_err,
   output logic              wr_err,
   output logic              itlb_inv_all,
   output logic              dtlb_inv_all,
   output logic              itlb_inv_ng,
   output logic              dtlb_inv_ng
);
   localparam int NUM_TLB = 2;
   localparam logic [DATA_W-1:0] CR4_FLUSH_MASK =
      (DATA_W'(1) << B_PSE) | (DATA_W'(1) << B_PAE) | (DATA_W'(1) << B_PGE);

   if (DATA_W < 32) begin : g_bad_width
      $error("DATA_W must hold bit 31 of CR0");
   end

   logic [DATA_W-1:0] cr0_q, cr2_q, cr3_q, cr4_q, cr8_q;
   logic [DATA_W-1:0] efer_q, flags_q, csattr_q, status_q;
   logic [DATA_W-1:0] m_efer, m_status, tsc_val;
   logic [DATA_W-1:0] cs_status;
   logic              pg_flip, wr_ok, fire_all, fire_ng;
   logic [NUM_TLB-1:0] inv_all_v, inv_ng_v;

   assign wr_ok  = wr_en && idx_legal(wr_idx) && !clr;
   assign wr_err = wr_en && !idx_legal(wr_idx);
   assign rd_err = !idx_legal(rd_idx);

   ctrk_mode #(.DATA_W(DATA_W)) i_mode (
      .cr0_q(cr0_q), .cr0_new(wr_data), .efer_q(efer_q), .flags_q(flags_q),
      .csattr_q(csattr_q), .status_q(status_q),
      .efer_n(m_efer), .status_n(m_status), .pg_flip(pg_flip));

   // code-segment attribute side effects
   always_comb begin
      cs_status = status_q;
      cs_status[S_CPL+:2] = wr_data[B_DPL+:2];
      if ((csattr_q[B_CSL] ^ wr_data[B_CSL]) && status_q[S_MODE])
         cs_status[S_SUB+:3] = wr_data[B_CSL] ? SUB_64 : SUB_COMPAT;
   end

   assign fire_all = wr_ok &&
      ((wr_idx == IX_CR0 && pg_flip) ||
       (wr_idx == IX_CR4 && |((cr4_q ^ wr_data) & CR4_FLUSH_MASK)));
   assign fire_ng  = wr_ok && wr_idx == IX_CR3;

   ctrk_flush #(.NUM_TLB(NUM_TLB)) i_flush (
      .clk(clk), .rst_n(rst_n), .fire_all(fire_all), .fire_ng(fire_ng),
      .inv_all(inv_all_v), .inv_ng(inv_ng_v));

   assign itlb_inv_all = inv_all_v[0];
   assign dtlb_inv_all = inv_all_v[1];
   assign itlb_inv_ng  = inv_ng_v[0];
   assign dtlb_inv_ng  = inv_ng_v[1];

   ctrk_tsc #(.DATA_W(DATA_W)) i_tsc (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .wr_tsc(wr_ok && wr_idx == IX_TSC), .wr_data(wr_data), .tsc_o(tsc_val));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n || clr) begin
         cr0_q <= '0; cr2_q <= '0; cr3_q <= '0; cr4_q <= '0; cr8_q <= '0;
         efer_q <= '0; flags_q <= '0; csattr_q <= '0; status_q <= '0;
      end else if (wr_ok) begin
         case (wr_idx)
            IX_CR0: begin
               cr0_q        <= wr_data | (DATA_W'(1) << B_ET);
               efer_q       <= m_efer;
               status_q     <= m_status;
            end
            IX_CR2:    cr2_q    <= wr_data;
            IX_CR3:    cr3_q    <= wr_data;
            IX_CR4:    cr4_q    <= wr_data;
            IX_CR8:    cr8_q    <= wr_data;
            IX_EFER:   efer_q   <= wr_data;
            IX_FLAGS:  flags_q  <= wr_data;
            IX_CSATTR: begin
               csattr_q <= wr_data;
               status_q <= cs_status;
            end
            IX_STATUS: status_q <= wr_data;
            default: ;
         endcase
      end
   end

   always_comb begin
      case (rd_idx)
         IX_CR0:    rd_data = cr0_q;
         IX_CR2:    rd_data = cr2_q;
         IX_CR3:    rd_data = cr3_q;
         IX_CR4:    rd_data = cr4_q;
         IX_CR8:    rd_data = cr8_q;
         IX_EFER:   rd_data = efer_q;
         IX_FLAGS:  rd_data = flags_q;
         IX_CSATTR: rd_data = csattr_q;
         IX_STATUS: rd_data = status_q;
         IX_TSC:    rd_data = tsc_val;
         default:   rd_data = '0;
      endcase
   end

   a_r5_et_forced: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == IX_CR0 && !clr) |=> cr0_q[B_ET]);
   a_r2_illegal_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_err && !clr) |=> ($stable(cr0_q) && $stable(cr2_q) && $stable(cr3_q) &&
                            $stable(cr4_q) && $stable(cr8_q) && $stable(efer_q) &&
                            $stable(flags_q) && $stable(csattr_q) && $stable(status_q)));
   a_r1_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cr0_q == '0 && efer_q == '0 && status_q == '0 && csattr_q == '0 &&
               !itlb_inv_all && !itlb_inv_ng));
   a_r9_cpl_copy: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == IX_CSATTR && !clr) |=> status_q[S_CPL+:2] == $past(wr_data[B_DPL+:2]));
   a_r3_long_mode: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == IX_CR0 && !clr && efer_q[B_LME] && (cr0_q[B_PG] != wr_data[B_PG]))
      |=> (efer_q[B_LMA] == $past(wr_data[B_PG]) && status_q[S_MODE] == $past(wr_data[B_PG])));
   a_r7_ng_origin: assert property (@(posedge clk) disable iff (!rst_n)
      (itlb_inv_ng || dtlb_inv_ng) |-> $past(wr_en && wr_idx == IX_CR3 && !clr));
endmodule

// File: tb/test_ctl_reg_tracker.sv
module test_ctl_reg_tracker;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clr = 1'b0;
   logic        wr_en = 1'b0;
   logic [4:0]  wr_idx = '0;
   logic [63:0] wr_data = '0;
   logic [4:0]  rd_idx = '0;
   logic [63:0] rd_data;
   logic        rd_err, wr_err;
   logic        itlb_inv_all, dtlb_inv_all, itlb_inv_ng, dtlb_inv_ng;

   int vectors = 0;
   int errors  = 0;
   logic [63:0] m [0:31];
   logic [63:0] mcyc;
   bit ex_all, ex_ng;

   always #2.5 clk = ~clk;

   ctl_reg_tracker #(.DATA_W(64)) i_ctl_reg_tracker (
      .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data), .rd_err(rd_err),
      .wr_err(wr_err), .itlb_inv_all(itlb_inv_all), .dtlb_inv_all(dtlb_inv_all),
      .itlb_inv_ng(itlb_inv_ng), .dtlb_inv_ng(dtlb_inv_ng));

   function automatic bit legal(input logic [4:0] i);
      return !(i == 1 || (i >= 5 && i <= 7) || (i >= 9 && i <= 15) || i > 20);
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_clear();
      for (int k = 0; k < 32; k++) m[k] = '0;
   endtask

   // one clock: drive at negedge, compare reads, advance model, compare pulses
   task automatic step(input bit we, input logic [4:0] wi, input logic [63:0] wd,
                       input logic [4:0] ri, input bit cl,
                       input string rt, input string ft);
      logic [63:0] expv;
      bit lng;
      int sub;
      wr_en = we; wr_idx = wi; wr_data = wd; rd_idx = ri; clr = cl;
      #1;
      if (!legal(ri))    expv = '0;
      else if (ri == 20) expv = m[20] + mcyc;
      else               expv = m[ri];
      chk(rt, rd_data, expv);
      chk("R2 rd_err", {63'd0, rd_err}, {63'd0, !legal(ri)});
      chk("R2 wr_err", {63'd0, wr_err}, {63'd0, we && !legal(wi)});
      ex_all = 0; ex_ng = 0;
      if (cl) model_clear();
      else if (we && legal(wi)) begin
         case (wi)
            0: begin
               if (m[0][31] != wd[31]) begin
                  ex_all = 1;
                  if (m[16][8]) begin m[16][10] = wd[31]; m[19][0] = wd[31]; end
               end
               lng = m[19][0];
               if (lng) sub = m[18][9] ? 4 : 3;
               else if (wd[0]) sub = m[17][17] ? 2 : 1;
               else sub = 0;
               m[19][3:1] = sub[2:0];
               m[0] = wd | 64'h10;
            end
            3: begin ex_ng = 1; m[3] = wd; end
            4: begin if (((m[4] ^ wd) & 64'hB0) != 0) ex_all = 1; m[4] = wd; end
            18: begin
               if ((m[18][9] != wd[9]) && m[19][0]) m[19][3:1] = wd[9] ? 3'd4 : 3'd3;
               m[19][5:4] = wd[6:5];
               m[18] = wd;
            end
            20: m[20] = wd - mcyc;
            default: m[wi] = wd;
         endcase
      end
      @(posedge clk);
      mcyc++;
      @(negedge clk);
      chk(ft, {63'd0, itlb_inv_all}, {63'd0, ex_all});
      chk(ft, {63'd0, dtlb_inv_all}, {63'd0, ex_all});
      chk(ft, {63'd0, itlb_inv_ng},  {63'd0, ex_ng});
      chk(ft, {63'd0, dtlb_inv_ng},  {63'd0, ex_ng});
   endtask

   task automatic wr(input logic [4:0] wi, input logic [63:0] wd, input string ft);
      step(1, wi, wd, 5'd0, 0, "R11", ft);
   endtask

   task automatic rd(input logic [4:0] ri, input string rt);
      step(0, 5'd0, '0, ri, 0, rt, "R6");
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      model_clear();
      mcyc = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state of every legal index
      for (int i = 0; i < 21; i++) if (legal(5'(i)) && i != 20) rd(5'(i), "R1");
      rd(5'd20, "R10");
      // R11: verbatim storage
      wr(5'd2, 64'hDEAD_BEEF_0123_4567, "R6");
      wr(5'd8, 64'h5, "R6");
      rd(5'd2, "R11"); rd(5'd8, "R11");
      // R2: illegal writes and reads
      wr(5'd1, 64'hFFFF, "R2");
      wr(5'd6, 64'hFFFF, "R2");
      wr(5'd12, 64'hFFFF, "R2");
      wr(5'd27, 64'hFFFF, "R2");
      rd(5'd1, "R2"); rd(5'd13, "R2"); rd(5'd30, "R2"); rd(5'd2, "R2");
      // R4/R5: protected, then virtual-8086, then real
      wr(5'd0, 64'h1, "R6");
      rd(5'd0, "R5"); rd(5'd19, "R4");
      wr(5'd17, 64'h2_0000, "R6");
      wr(5'd0, 64'h1, "R6");
      rd(5'd19, "R4");
      wr(5'd0, 64'h0, "R6");
      rd(5'd19, "R4"); rd(5'd0, "R5");
      // R6 without LME: pulse but no long mode
      wr(5'd17, 64'h0, "R6");
      wr(5'd0, 64'h8000_0001, "R6");
      rd(5'd16, "R3"); rd(5'd19, "R3");
      wr(5'd0, 64'h1, "R6");
      // R3/R6: long-mode activation, compatibility submode
      wr(5'd16, 64'h100, "R6");
      wr(5'd0, 64'h8000_0001, "R6");
      rd(5'd16, "R3"); rd(5'd19, "R4");
      // R9: long bit on in long mode, DPL 3
      wr(5'd18, 64'h260, "R6");
      rd(5'd19, "R9");
      wr(5'd18, 64'h020, "R6");
      rd(5'd19, "R9");
      wr(5'd18, 64'h240, "R6");
      rd(5'd19, "R9");
      // R3: long mode off
      wr(5'd0, 64'h1, "R6");
      rd(5'd16, "R3"); rd(5'd19, "R4");
      // R9 outside long mode: submode kept
      wr(5'd18, 64'h000, "R6");
      rd(5'd19, "R9");
      // R8: CR4 flush mask
      wr(5'd4, 64'h20, "R8");
      wr(5'd4, 64'h21, "R8");
      wr(5'd4, 64'h01, "R8");
      wr(5'd4, 64'h81, "R8");
      wr(5'd4, 64'h91, "R8");
      rd(5'd4, "R8");
      // R7: back-to-back CR3 writes
      wr(5'd3, 64'h1000, "R7");
      wr(5'd3, 64'h2000, "R7");
      rd(5'd3, "R7");
      // R10: time stamp
      rd(5'd20, "R10");
      wr(5'd20, 64'h1_0000_0000, "R6");
      rd(5'd20, "R10"); rd(5'd20, "R10"); rd(5'd20, "R10");
      wr(5'd20, 64'hFFFF_FFFF_FFFF_FFFF, "R6");
      rd(5'd20, "R10"); rd(5'd20, "R10");
      // R1: clear beats a simultaneous CR0 write, no pulse
      wr(5'd16, 64'h100, "R6");
      step(1, 5'd0, 64'h8000_0001, 5'd16, 1, "R1", "R1");
      rd(5'd0, "R1"); rd(5'd16, "R1"); rd(5'd19, "R1"); rd(5'd20, "R1");
      rd(5'd4, "R1"); rd(5'd2, "R1");
      finish_run();
   end
endmodule